// File: doc/BRIEF.md
# Speculation-Aware Register File with Deferred Fault Tags

This block is a multi-ported register file in which every entry carries a one-bit tag that records a deferred terminating exception. It lets a statically scheduled pipeline hoist instructions above branches. A hoisted (speculative) instruction whose result would have caused a terminating exception, such as a protection violation, does not trap. Its destination entry is tagged instead. The tag turns into a fault only when a non-speculative instruction consumes that entry. A tagged result that no committed instruction ever reads therefore costs nothing.

There are two combinational read ports and one write port that updates on the clock edge. The write port carries the destination index and data, a speculative flag, a two-bit exception kind and a flag that says whether one of the writing instruction's own sources was tagged. The read side carries a valid/speculative qualifier for the reading instruction and a use flag per source. The outputs are the data and the tag of each source, a fault strobe with the index of the offending register, and two same-cycle exception strobes for the write port. A resumable exception, such as a page fault, is reported at once whether the writer is speculative or not. Trap handling and pipeline flushing live outside the block.

Top module: `poison_regfile`

## Requirements
- R1: Reset, with active-low `rstN`, clears every tag and every data entry to zero.
- R2: Register 0 always reads as data zero with a clear tag, and any write to it leaves it unchanged. A terminating or resumable strobe still fires for it.
- R3: A write with exception kind 2'b00 (none) stores `wrData` and clears the destination tag, unless `wrSpec` and `wrSrcPoison` are both high. The write is seen on the read ports after the next rising edge.
- R4: A write with a terminating kind (2'b10, or 2'b11 treated the same) and `wrSpec` high stores `wrData`, sets the destination tag and never asserts `termTrap`.
- R5: A write with a terminating kind and `wrSpec` low asserts `termTrap` in the same cycle and leaves the destination entry (data and tag) unchanged.
- R6: A write with kind 2'b01 (resumable) asserts `resumeTrap` in the same cycle for both speculative and non-speculative writers, and leaves the destination entry unchanged.
- R7: When `instValid` is high, `instSpec` is low and a source with its use flag set has its tag set, `faultValid` is high in the same cycle and `faultIdx` gives that source's index.
- R8: A speculative reader (`instSpec` high) of a tagged source never raises `faultValid`. A speculative write with kind none and `wrSrcPoison` high sets the destination tag, so the tag passes on.
- R9: When both used sources of a non-speculative reader are tagged, `faultIdx` reports the index on port A.
- R10: A tagged register that is not read by a valid non-speculative instruction with its use flag set causes no fault.
- R11: `srcAPoison` and `srcBPoison` show the current tag of the addressed registers, whatever the reader's qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write port valid |
| wrIdx | input | IDX_W | Destination register index |
| wrData | input | DATA_W | Write data |
| wrSpec | input | 1 | Writer is speculative |
| wrExc | input | 2 | Exception kind: 00 none, 01 resumable, 1x terminating |
| wrSrcPoison | input | 1 | One of the writer's sources was tagged |
| instValid | input | 1 | Reading instruction valid |
| instSpec | input | 1 | Reading instruction is speculative |
| srcAUse | input | 1 | Port A operand is consumed |
| srcAIdx | input | IDX_W | Port A register index |
| srcBUse | input | 1 | Port B operand is consumed |
| srcBIdx | input | IDX_W | Port B register index |
| srcAData | output | DATA_W | Port A data |
| srcAPoison | output | 1 | Port A tag |
| srcBData | output | DATA_W | Port B data |
| srcBPoison | output | 1 | Port B tag |
| faultValid | output | 1 | Non-speculative use of a tagged register |
| faultIdx | output | IDX_W | Register that caused the fault |
| resumeTrap | output | 1 | Resumable exception on the write port |
| termTrap | output | 1 | Non-speculative terminating exception on the write port |

## Verification
The hardest case to reach from the ports is a committed reader whose two sources are both tagged. It needs two earlier speculative terminating writes to different non-zero registers, with no clean write to either of them in between. The stimulus first builds that state with directed writes and then reads the pair in both port orders to expose the port-A priority. A random phase follows. It uses only eight registers and gives speculation and terminating kinds a high weight, so tags build up, pass on through `wrSrcPoison` and get cleared again. The behavioural model is compared on every cycle.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;
  typedef enum logic [1:0] {
    EXC_NONE   = 2'b00,
    EXC_RESUME = 2'b01,
    EXC_TERM   = 2'b10,
    EXC_TERM2  = 2'b11
  } excKind_t;

  typedef struct packed {
    logic writeData;
    logic setPoison;
    logic clearPoison;
  } rfStrobe_t;
endpackage

// File: rtl/prf_datapath.sv
module prf_datapath
  import poison_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcAPoison,
  output logic [DATA_W-1:0] srcBData,
  output logic              srcBPoison
);
  logic [DATA_W-1:0] regData [NUM_REGS];
  logic [NUM_REGS-1:0] poisonVec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == 0) begin : gZero
      assign regData[g]   = '0;
      assign poisonVec[g] = 1'b0;
    end else begin : gReg
      logic hit;
      assign hit = (wrIdx == IDX_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regData[g]   <= '0;
          poisonVec[g] <= 1'b0;
        end else if (hit && strobe.writeData) begin
          regData[g] <= wrData;
          if (strobe.setPoison)
            poisonVec[g] <= 1'b1;
          else if (strobe.clearPoison)
            poisonVec[g] <= 1'b0;
        end
      end
    end
  end

  assign srcAData   = regData[srcAIdx];
  assign srcBData   = regData[srcBIdx];
  assign srcAPoison = poisonVec[srcAIdx];
  assign srcBPoison = poisonVec[srcBIdx];
endmodule

// File: rtl/prf_control.sv
module prf_control
  import poison_rf_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrSpec,
  input  logic [1:0]       wrExc,
  input  logic             wrSrcPoison,
  input  logic             instValid,
  input  logic             instSpec,
  input  logic             srcAUse,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic             srcAPoison,
  input  logic             srcBUse,
  input  logic [IDX_W-1:0] srcBIdx,
  input  logic             srcBPoison,
  output rfStrobe_t        strobe,
  output logic             resumeTrap,
  output logic             termTrap,
  output logic             faultValid,
  output logic [IDX_W-1:0] faultIdx
);
  excKind_t kind;
  logic isResume, isTerm, committed, hitA, hitB;

  always_comb begin
    kind     = excKind_t'(wrExc);
    isResume = (kind == EXC_RESUME);
    isTerm   = (kind == EXC_TERM) || (kind == EXC_TERM2);

    strobe.writeData   = wrEn && (wrIdx != '0) && !isResume && !(isTerm && !wrSpec);
    strobe.setPoison   = strobe.writeData && wrSpec && (isTerm || wrSrcPoison);
    strobe.clearPoison = strobe.writeData && !strobe.setPoison;

    resumeTrap = wrEn && isResume;
    termTrap   = wrEn && isTerm && !wrSpec;

    committed  = instValid && !instSpec;
    hitA       = committed && srcAUse && srcAPoison;
    hitB       = committed && srcBUse && srcBPoison;
    faultValid = hitA || hitB;
    faultIdx   = hitA ? srcAIdx : (hitB ? srcBIdx : '0);
  end
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import poison_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSpec,
  input  logic [1:0]        wrExc,
  input  logic              wrSrcPoison,
  input  logic              instValid,
  input  logic              instSpec,
  input  logic              srcAUse,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic              srcBUse,
  input  logic [IDX_W-1:0]  srcBIdx,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcAPoison,
  output logic [DATA_W-1:0] srcBData,
  output logic              srcBPoison,
  output logic              faultValid,
  output logic [IDX_W-1:0]  faultIdx,
  output logic              resumeTrap,
  output logic              termTrap
);
  rfStrobe_t strobe;

  prf_control #(.IDX_W(IDX_W)) uCtrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSpec(wrSpec), .wrExc(wrExc),
    .wrSrcPoison(wrSrcPoison), .instValid(instValid), .instSpec(instSpec),
    .srcAUse(srcAUse), .srcAIdx(srcAIdx), .srcAPoison(srcAPoison),
    .srcBUse(srcBUse), .srcBIdx(srcBIdx), .srcBPoison(srcBPoison),
    .strobe(strobe), .resumeTrap(resumeTrap), .termTrap(termTrap),
    .faultValid(faultValid), .faultIdx(faultIdx)
  );

  prf_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .wrData(wrData),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .srcAData(srcAData), .srcAPoison(srcAPoison),
    .srcBData(srcBData), .srcBPoison(srcBPoison)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              wrSpec,
  input logic [1:0]        wrExc,
  input logic              wrSrcPoison,
  input logic              instValid,
  input logic              instSpec,
  input logic              srcAUse,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic [DATA_W-1:0] srcAData,
  input logic              srcAPoison,
  input logic              faultValid,
  input logic [IDX_W-1:0]  faultIdx,
  input logic              resumeTrap,
  input logic              termTrap
);
  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcAIdx == '0) |-> (srcAData == '0 && !srcAPoison));

  assert_clean_write_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrExc == 2'b00 && !wrSrcPoison && wrIdx != '0)
      |=> (srcAIdx != $past(wrIdx) || !srcAPoison));

  assert_spec_term_tags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSpec && wrExc[1] && wrIdx != '0)
      |=> (srcAIdx != $past(wrIdx) || srcAPoison));

  assert_spec_never_traps_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrSpec |-> !termTrap);

  assert_resume_signalled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrExc == 2'b01) |-> resumeTrap);

  assert_spec_reader_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instSpec) |-> !faultValid);

  assert_port_a_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && srcAUse && srcAPoison) |-> (faultIdx == srcAIdx));
endmodule

bind poison_regfile prf_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrSpec(wrSpec),
  .wrExc(wrExc), .wrSrcPoison(wrSrcPoison), .instValid(instValid),
  .instSpec(instSpec), .srcAUse(srcAUse), .srcAIdx(srcAIdx),
  .srcAData(srcAData), .srcAPoison(srcAPoison), .faultValid(faultValid),
  .faultIdx(faultIdx), .resumeTrap(resumeTrap), .termTrap(termTrap)
);

// File: tb/sim_poison_regfile.sv
`timescale 1ns/1ps
module sim_poison_regfile;
  localparam int DW = 32;
  localparam int NR = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrSpec = 0, wrSrcPoison = 0;
  logic [IW-1:0] wrIdx = '0, srcAIdx = '0, srcBIdx = '0;
  logic [DW-1:0] wrData = '0;
  logic [1:0] wrExc = 2'b00;
  logic instValid = 0, instSpec = 0, srcAUse = 0, srcBUse = 0;
  logic [DW-1:0] srcAData, srcBData;
  logic srcAPoison, srcBPoison, faultValid, resumeTrap, termTrap;
  logic [IW-1:0] faultIdx;

  int nCmp = 0, nBad = 0;
  logic [DW-1:0] refData [NR];
  bit refPois [NR];

  always #2 clk = ~clk;

  poison_regfile #(.DATA_W(DW), .NUM_REGS(NR)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrSpec(wrSpec), .wrExc(wrExc), .wrSrcPoison(wrSrcPoison),
    .instValid(instValid), .instSpec(instSpec), .srcAUse(srcAUse),
    .srcAIdx(srcAIdx), .srcBUse(srcBUse), .srcBIdx(srcBIdx),
    .srcAData(srcAData), .srcAPoison(srcAPoison), .srcBData(srcBData),
    .srcBPoison(srcBPoison), .faultValid(faultValid), .faultIdx(faultIdx),
    .resumeTrap(resumeTrap), .termTrap(termTrap)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic setIdle();
    wrEn = 0; wrSpec = 0; wrSrcPoison = 0; wrExc = 2'b00; wrIdx = '0; wrData = '0;
    instValid = 0; instSpec = 0; srcAUse = 0; srcBUse = 0; srcAIdx = '0; srcBIdx = '0;
  endtask

  // compare all outputs against the model, then advance one clock
  task automatic cycle(input string poisTag = "R11");
    bit pa, pb, expFault, isTerm;
    logic [IW-1:0] expIdx;
    #1;
    check(srcAIdx == 0 ? "R2" : "R3", srcAData, refData[srcAIdx]);
    check(srcBIdx == 0 ? "R2" : "R3", srcBData, refData[srcBIdx]);
    check(poisTag, DW'(srcAPoison), DW'(refPois[srcAIdx]));
    check(poisTag, DW'(srcBPoison), DW'(refPois[srcBIdx]));
    pa = instValid && !instSpec && srcAUse && refPois[srcAIdx];
    pb = instValid && !instSpec && srcBUse && refPois[srcBIdx];
    expFault = pa || pb;
    expIdx = pa ? srcAIdx : srcBIdx;
    check(instSpec ? "R8" : "R7", DW'(faultValid), DW'(expFault));
    if (expFault) check((pa && pb) ? "R9" : "R7", DW'(faultIdx), DW'(expIdx));
    isTerm = wrExc[1];
    check("R6", DW'(resumeTrap), DW'(wrEn && wrExc == 2'b01));
    check(wrSpec ? "R4" : "R5", DW'(termTrap), DW'(wrEn && isTerm && !wrSpec));
    @(posedge clk);
    if (wrEn && wrExc != 2'b01 && !(isTerm && !wrSpec) && wrIdx != 0) begin
      refData[wrIdx] = wrData;
      refPois[wrIdx] = wrSpec && (isTerm || wrSrcPoison);
    end
    @(negedge clk);
  endtask

  task automatic doWrite(input int idx, input logic [DW-1:0] d, input bit spec,
                         input logic [1:0] exc, input bit sp);
    setIdle();
    wrEn = 1; wrIdx = IW'(idx); wrData = d; wrSpec = spec; wrExc = exc; wrSrcPoison = sp;
    cycle();
  endtask

  task automatic doRead(input int a, input bit ua, input int b, input bit ub, input bit spec);
    setIdle();
    instValid = 1; instSpec = spec; srcAIdx = IW'(a); srcAUse = ua; srcBIdx = IW'(b); srcBUse = ub;
    cycle();
  endtask

  initial begin
    #(4 * 200000);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin refData[i] = '0; refPois[i] = 0; end
    setIdle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state on every entry
    for (int i = 0; i < NR; i++) begin
      setIdle(); srcAIdx = IW'(i); srcBIdx = IW'(NR - 1 - i); instValid = 1;
      srcAUse = 1; srcBUse = 1;
      cycle("R1");
    end
    // R3: clean write then read back
    doWrite(3, 32'h1234_5678, 0, 2'b00, 0);
    doRead(3, 1, 3, 1, 0);
    // R4: speculative terminating write tags the register
    doWrite(5, 32'hDEAD_0005, 1, 2'b10, 0);
    doRead(5, 0, 0, 0, 1);
    // R5: committed terminating write traps and leaves reg 6 alone
    doWrite(6, 32'h6666_6666, 0, 2'b10, 0);
    doRead(6, 1, 6, 1, 0);
    // R6: resumable, both speculative and committed
    doWrite(7, 32'h7777_7777, 1, 2'b01, 0);
    doWrite(7, 32'h7777_7777, 0, 2'b01, 0);
    doRead(7, 1, 7, 1, 0);
    // R9: two tagged sources, both orders
    doWrite(8, 32'h0000_0008, 1, 2'b11, 0);
    doRead(5, 1, 8, 1, 0);
    doRead(8, 1, 5, 1, 0);
    // R7: single tagged source on port B
    doRead(3, 1, 8, 1, 0);
    // R10: tagged but unused or not valid
    doRead(3, 1, 5, 0, 0);
    setIdle(); srcAIdx = 5; srcAUse = 1; cycle("R10");
    // R8: speculative reader quiet, tag passes on
    doRead(5, 1, 8, 1, 1);
    doWrite(9, 32'h9999_0000, 1, 2'b00, 1);
    doRead(9, 1, 0, 0, 0);
    // R2: register 0 immune
    doWrite(0, 32'hFFFF_FFFF, 1, 2'b10, 0);
    doWrite(0, 32'hFFFF_FFFF, 0, 2'b00, 0);
    doRead(0, 1, 0, 1, 0);
    // R3: clean speculative write clears a tag
    doWrite(5, 32'h5555_5555, 1, 2'b00, 0);
    doRead(5, 1, 5, 1, 0);
    // random phase over eight registers
    for (int n = 0; n < 4000; n++) begin
      wrEn = ($urandom % 4) != 0;
      wrIdx = IW'($urandom % 8);
      wrData = $urandom;
      wrSpec = ($urandom % 3) != 0;
      wrExc = 2'($urandom % 4);
      if (($urandom % 2) == 0) wrExc = 2'b00;
      wrSrcPoison = ($urandom % 3) == 0;
      instValid = ($urandom % 4) != 0;
      instSpec = $urandom % 2;
      srcAUse = $urandom % 2; srcBUse = $urandom % 2;
      srcAIdx = IW'($urandom % 8); srcBIdx = IW'($urandom % 8);
      cycle();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule